// File: doc/BRIEF.md
# Eight-pin GPIO port with timed power-up default

This block is a general-purpose I/O port of eight pins. Each pin is an input or an output according to its own direction bit. An output-data register supplies the level of every pin set as an output. The pad inputs pass through a two-flop synchronizer and can be read back. Software reaches all of this through a small register port: a write strobe, an address, write data, and combinational read data selected by the same address.

Out of reset every pin floats. A tick counter, sized from a clock-frequency parameter and a delay parameter (140 ms by default), then runs down the power-up window. When the window closes, every pin turns into an output driven low. Software may write the direction or data registers while the window is still open. Such a write is held without taking effect. When the window closes, the held value is used in place of the default. Reading the direction or data register always returns the value currently in force at the pins.

Register map (addr_i): 0 = direction (bit i set makes pin i an output), 1 = output data, 2 = synchronized pad inputs (read-only), 3 = unused (reads 0).

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and right after it is released, pin_oe_o and pin_out_o are 0, and reads of addresses 0, 1 and 3 return 0.
- R2: With the delay set to N clock cycles, every pin stays floating (pin_oe_o = 0) during the first N-1 rising edges after reset is released.
- R3: After rising edge N, when no register write came earlier, pin_oe_o is 0xFF and pin_out_o is 0x00.
- R4: A write to address 0 before or at edge N leaves pin_oe_o at 0 until edge N. After edge N, pin_oe_o equals the last value written. The all-output default does not override it.
- R5: A write to address 1 before edge N has no effect on pin_out_o until edge N. After edge N, pin_out_o equals that written value. With no such write, it is 0.
- R6: After edge N, a write to address 0 or 1 changes pin_oe_o or pin_out_o at the next rising edge. Bit i of the direction register controls only pin i.
- R7: Address 2 reads the value pin_i had two rising edges earlier. After one edge, the old value still shows.
- R8: Address 0 reads back the pin_oe_o value currently in force, and address 1 reads back the pin_out_o value currently in force.
- R9: Writes to address 2 or 3 change neither pin_oe_o nor pin_out_o, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pin_i | input | 8 | Pad input levels |
| pin_oe_o | output | 8 | Per-pin output enable (1 = driven) |
| pin_out_o | output | 8 | Per-pin output level |

## Verification
The assertions assume that pin_i and the register-port inputs are stable around each rising clock edge. They also assume reset is held for at least one edge. The synchronizer check further assumes that pin_i was sampled on the two edges after reset, so it is gated until two edges have passed. The bench drives every input only on falling edges and holds reset low for several cycles. It sets the delay to 140 cycles so that the default edge and a write landing exactly on it can both be reached directly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_DOUT = 2'd1,
    REG_DIN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_startup_timer.sv
module gpio_startup_timer #(
  parameter int unsigned CLK_FREQ_HZ = 4_915_200,
  parameter int unsigned DELAY_MS    = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic expire_o,
  output logic done_o
);
  localparam int unsigned TICKS_RAW = (CLK_FREQ_HZ / 1000) * DELAY_MS;
  localparam int unsigned TICKS     = (TICKS_RAW < 1) ? 1 : TICKS_RAW;
  localparam int unsigned CNT_W     = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign expire_o = !done_q && (cnt_q == LAST);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (expire_o) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R2
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  // R3
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_sync_o
);
  logic [NUM_PINS-1:0] s1_q, s2_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= pin_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign pin_sync_o = s2_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 1'b1;
  end

  // R7
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (s2_q == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                expire_i,
  input  logic                done_i,
  input  logic                wr_dir_i,
  input  logic                wr_out_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] dir_eff_o,
  output logic [NUM_PINS-1:0] out_eff_o
);
  logic [NUM_PINS-1:0] dir_q, out_q;
  logic                dir_seen_q, out_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q      <= '0;
      dir_seen_q <= 1'b0;
    end else if (wr_dir_i) begin
      dir_q      <= wdata_i;
      dir_seen_q <= 1'b1;
    end else if (expire_i && !dir_seen_q) begin
      dir_q <= '1; // default: all outputs
    end
  end

  // output default is low, already the reset value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q      <= '0;
      out_seen_q <= 1'b0;
    end else if (wr_out_i) begin
      out_q      <= wdata_i;
      out_seen_q <= 1'b1;
    end
  end

  assign dir_eff_o = done_i ? dir_q : '0;
  assign out_eff_o = done_i ? out_q : '0;

  // R3
  default_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_i) && !$past(dir_seen_q) && !$past(wr_dir_i)) |-> (dir_eff_o == '1));

  // R5
  default_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_i) && !$past(out_seen_q) && !$past(wr_out_i)) |-> (out_eff_o == '0));

  // R4
  held_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_i) && $past(dir_seen_q) && !$past(wr_dir_i)) |-> (dir_q == $past(dir_q)));

  // R6
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && wr_dir_i) |=> (dir_eff_o == $past(wdata_i)));

  // R6
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_dir_i) |=> $stable(dir_eff_o));

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_out_i) |=> $stable(out_eff_o));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned CLK_FREQ_HZ = 4_915_200,
  parameter int unsigned DELAY_MS    = 140
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o
);
  logic                expire, done;
  logic [NUM_PINS-1:0] pin_sync, dir_eff, out_eff;
  reg_sel_e            sel;

  assign sel = reg_sel_e'(addr_i);

  gpio_startup_timer #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ),
    .DELAY_MS   (DELAY_MS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .expire_o(expire),
    .done_o  (done)
  );

  gpio_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_i),
    .pin_sync_o(pin_sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .done_i   (done),
    .wr_dir_i (wr_en_i && (sel == REG_DIR)),
    .wr_out_i (wr_en_i && (sel == REG_DOUT)),
    .wdata_i  (wdata_i),
    .dir_eff_o(dir_eff),
    .out_eff_o(out_eff)
  );

  assign pin_oe_o  = dir_eff;
  assign pin_out_o = out_eff;

  always_comb begin
    unique case (sel)
      REG_DIR:  rdata_o = dir_eff;
      REG_DOUT: rdata_o = out_eff;
      REG_DIN:  rdata_o = pin_sync;
      default:  rdata_o = '0;
    endcase
  end

  // R2
  float_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done && !$past(done)) |-> (pin_oe_o == '0));

  // R9
  ignored_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && wr_en_i && (sel inside {REG_DIN, REG_NONE})) |=> ($stable(pin_oe_o) && $stable(pin_out_o)));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 140;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_oe_o;
  logic [7:0] pin_out_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_port #(.NUM_PINS(8), .CLK_FREQ_HZ(1000), .DELAY_MS(140)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    wr_en_i = 1'b0;
    pin_i   = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 oe in reset", pin_oe_o, 8'h00);
    check("R1 out in reset", pin_out_o, 8'h00);
    do_reset();
    read_reg(2'd0, d); check("R1 dir read", d, 8'h00);
    read_reg(2'd1, d); check("R1 data read", d, 8'h00);
    read_reg(2'd3, d); check("R1 unused read", d, 8'h00);
  endtask

  task automatic t_default();
    logic [7:0] d;
    do_reset();
    wait_until(TICKS - 1);
    check("R2 float before expiry", pin_oe_o, 8'h00);
    wait_until(TICKS);
    check("R3 all outputs", pin_oe_o, 8'hFF);
    check("R3 driven low", pin_out_o, 8'h00);
    read_reg(2'd0, d); check("R8 dir read after default", d, 8'hFF);
  endtask

  task automatic t_held();
    logic [7:0] d;
    do_reset();
    wait_until(9);
    write_reg(2'd0, 8'h5A);
    write_reg(2'd1, 8'hC3);
    check("R4 held dir not applied", pin_oe_o, 8'h00);
    check("R5 held data not applied", pin_out_o, 8'h00);
    read_reg(2'd0, d); check("R8 dir read while held", d, 8'h00);
    read_reg(2'd1, d); check("R8 data read while held", d, 8'h00);
    wait_until(TICKS - 1);
    check("R2 float with held writes", pin_oe_o, 8'h00);
    wait_until(TICKS);
    check("R4 held dir applied", pin_oe_o, 8'h5A);
    check("R5 held data applied", pin_out_o, 8'hC3);
    read_reg(2'd1, d); check("R8 data read after apply", d, 8'hC3);
  endtask

  task automatic t_dir_only();
    do_reset();
    wait_until(20);
    write_reg(2'd0, 8'h0F);
    wait_until(TICKS);
    check("R4 dir only applied", pin_oe_o, 8'h0F);
    check("R5 data default low", pin_out_o, 8'h00);
  endtask

  task automatic t_boundary();
    do_reset();
    wait_until(TICKS - 1);
    write_reg(2'd0, 8'h33);
    check("R4 write at expiry edge wins", pin_oe_o, 8'h33);
  endtask

  task automatic t_runtime();
    logic [7:0] d;
    do_reset();
    wait_until(TICKS);
    write_reg(2'd0, 8'h81);
    check("R6 dir write live", pin_oe_o, 8'h81);
    write_reg(2'd1, 8'h7E);
    check("R6 data write live", pin_out_o, 8'h7E);
    write_reg(2'd0, 8'h80);
    check("R6 single pin turned to input", pin_oe_o, 8'h80);
    read_reg(2'd0, d); check("R8 dir readback", d, 8'h80);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    do_reset();
    @(negedge clk_i);
    pin_i = 8'hA5;
    @(negedge clk_i);
    read_reg(2'd2, d); check("R7 one edge old value", d, 8'h00);
    @(negedge clk_i);
    read_reg(2'd2, d); check("R7 two edges new value", d, 8'hA5);
    pin_i = 8'h3C;
    repeat (2) @(negedge clk_i);
    read_reg(2'd2, d); check("R7 second pattern", d, 8'h3C);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    do_reset();
    wait_until(TICKS);
    write_reg(2'd0, 8'hF0);
    write_reg(2'd1, 8'h55);
    write_reg(2'd2, 8'h0F);
    write_reg(2'd3, 8'hAA);
    check("R9 oe unchanged", pin_oe_o, 8'hF0);
    check("R9 out unchanged", pin_out_o, 8'h55);
    read_reg(2'd3, d); check("R9 unused reads zero", d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_default();
    t_held();
    t_dir_only();
    t_boundary();
    t_runtime();
    t_sync();
    t_ignored();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule